// File: doc/BRIEF.md
# Parking Occupancy Up/Down Counter

This block tracks how many cars are inside a garage with a fixed number of spaces, 100 at the default setting. Two sensor inputs, one at the entrance and one at the exit, each give a pulse per passing car. Both inputs are synchronised to the block clock and edge-detected, so a pulse of any width gives exactly one count step. A registered direction flag is set by an entry pulse and cleared by an exit pulse, and that flag selects whether the step counts up or down.

The count is held as a chain of cascaded decimal digits. Each digit passes its carry or borrow to the next one. When the count reaches capacity, the top digit's carry sets a full flag, and the digits show zeros. That flag drives the full sign and the gate-lower output. An exit from a full garage clears the flag at once and leaves every digit at 9. The count saturates at both ends. An entry that arrives together with an exit cancels it.

Top module: `park_occupancy`

## Requirements
- R1: After reset, `occ_bcd` is 0, and `full_sign` and `gate_lower` are low.
- R2: An entry pulse on a non-full garage adds one to the count. `occ_bcd[3:0]` holds the units digit and `occ_bcd[7:4]` the tens digit, both in BCD.
- R3: An exit pulse on a non-empty garage subtracts one from the count.
- R4: A sensor pulse gives exactly one count step, whatever its length in cycles, provided the input is low for at least two cycles between pulses.
- R5: The outputs show a step from the third rising clock edge after the sensor input rises, and not before that edge.
- R6: Each digit stays within 0 to 9. Stepping up from 9 gives 0 with a carry into the next digit, and stepping down from 0 gives 9 with a borrow.
- R7: When the count reaches capacity (100), `full_sign` and `gate_lower` go high together and `occ_bcd` reads 0.
- R8: An entry pulse while full is ignored. The count stays at capacity.
- R9: An exit pulse while full lowers `full_sign` and `gate_lower` and sets every digit to 9 (count 99).
- R10: An exit pulse while the count is 0 and not full is ignored.
- R11: If an entry and an exit are detected in the same cycle, neither the count nor the full flag changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| entry_sense | input | 1 | Entrance sensor pulse, asynchronous |
| exit_sense | input | 1 | Exit sensor pulse, asynchronous |
| occ_bcd | output | 4*NUM_DIGITS | Occupancy digits in BCD, units digit in the lowest nibble |
| full_sign | output | 1 | High while the garage is at capacity |
| gate_lower | output | 1 | High to lower the entrance gate bar, same timing as `full_sign` |

## Verification
A bad direction flag or a broken carry chain shows at the port one step later. The digits then differ from the running count by more than one, or a nibble leaves the range 0 to 9. A full flag that sets or clears at the wrong time shows at the capacity boundary. The count then reads 00 without the sign, or it fails to stop at capacity. A faulty edge detector shows as extra steps during a long pulse, or as a step that arrives on the wrong edge. All of these appear within three clock edges of the sensor pulse that exposes them.

// File: rtl/park_pkg.sv
package park_pkg;
    localparam int BCD_W = 4;
    typedef logic [BCD_W-1:0] bcd_t;
    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } dir_e;
endpackage

// File: rtl/park_edge_sync.sv
module park_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[STAGES-2:0], din};
        st_d.prev = st_q.sync[STAGES-1];
        rise      = st_q.sync[STAGES-1] & ~st_q.prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_SINGLE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise); // R4
endmodule

// File: rtl/park_bcd_digit.sv
module park_bcd_digit
    import park_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic step_en,
    input  logic count_up,
    output bcd_t digit,
    output logic wrap
);
    bcd_t dig_d, dig_q;

    always_comb begin
        dig_d = dig_q;
        wrap  = count_up ? (dig_q == bcd_t'(9)) : (dig_q == bcd_t'(0));
        if (step_en) begin
            if (count_up) dig_d = wrap ? bcd_t'(0) : dig_q + bcd_t'(1);
            else          dig_d = wrap ? bcd_t'(9) : dig_q - bcd_t'(1);
        end
        digit = dig_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dig_q <= '0;
        else        dig_q <= dig_d;
    end

    AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        dig_q <= bcd_t'(9)); // R6
    AST_DIGIT_UP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && count_up && dig_q == bcd_t'(9)) |=> dig_q == bcd_t'(0)); // R6
    AST_DIGIT_DN_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !count_up && dig_q == bcd_t'(0)) |=> dig_q == bcd_t'(9)); // R6
endmodule

// File: rtl/park_occupancy.sv
module park_occupancy
    import park_pkg::*;
#(
    parameter int NUM_DIGITS  = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        entry_sense,
    input  logic                        exit_sense,
    output logic [NUM_DIGITS*BCD_W-1:0] occ_bcd,
    output logic                        full_sign,
    output logic                        gate_lower
);
    localparam int DIG_W = NUM_DIGITS * BCD_W;

    typedef struct packed {
        dir_e dir;
        logic full;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic                  ent_rise, ext_rise;
    logic                  take_up, take_dn, count_up, all_zero;
    logic [NUM_DIGITS:0]   chain_en;
    logic [NUM_DIGITS-1:0] dig_wrap;
    logic [NUM_DIGITS-1:0] dig_zero;
    logic [DIG_W-1:0]      digits;

    park_edge_sync #(.STAGES(SYNC_STAGES)) u_entry_sync (
        .clk(clk), .rst_n(rst_n), .din(entry_sense), .rise(ent_rise)
    );
    park_edge_sync #(.STAGES(SYNC_STAGES)) u_exit_sync (
        .clk(clk), .rst_n(rst_n), .din(exit_sense), .rise(ext_rise)
    );

    generate
        for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_digit
            bcd_t d;
            park_bcd_digit u_digit (
                .clk(clk), .rst_n(rst_n),
                .step_en(chain_en[g]), .count_up(count_up),
                .digit(d), .wrap(dig_wrap[g])
            );
            assign digits[g*BCD_W +: BCD_W] = d;
            assign dig_zero[g]              = (d == bcd_t'(0));
            assign chain_en[g+1]            = chain_en[g] & dig_wrap[g];
        end
    endgenerate

    always_comb begin
        ctl_d    = ctl_q;
        all_zero = &dig_zero;
        if (ent_rise && !ext_rise)      ctl_d.dir = DIR_UP;
        else if (ext_rise && !ent_rise) ctl_d.dir = DIR_DOWN;
        count_up = (ctl_d.dir == DIR_UP);
        take_up  = ent_rise & ~ext_rise & ~ctl_q.full;
        take_dn  = ext_rise & ~ent_rise & ~(~ctl_q.full & all_zero);
        chain_en[0] = take_up | take_dn;
        if (take_up && chain_en[NUM_DIGITS]) ctl_d.full = 1'b1;
        if (take_dn && ctl_q.full)           ctl_d.full = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{dir: DIR_DOWN, full: 1'b0};
        else        ctl_q <= ctl_d;
    end

    assign occ_bcd    = digits;
    assign full_sign  = ctl_q.full;
    assign gate_lower = ctl_q.full;

    AST_FULL_DIGITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        full_sign |-> occ_bcd == '0); // R7
    AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ent_rise && ext_rise) |=> ($stable(occ_bcd) && $stable(full_sign))); // R11
    AST_EMPTY_EXIT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_rise && !ent_rise && !full_sign && occ_bcd == '0) |=> (occ_bcd == '0 && !full_sign)); // R10
    AST_FULL_ENTRY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (ent_rise && !ext_rise && full_sign) |=> (full_sign && occ_bcd == '0)); // R8
    AST_FULL_EXIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_rise && !ent_rise && full_sign) |=> (!full_sign && occ_bcd == {NUM_DIGITS{4'd9}})); // R9
    AST_NO_STEP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ent_rise && !ext_rise) |=> ($stable(occ_bcd) && $stable(full_sign))); // R4
endmodule

// File: tb/park_occupancy_tb_top.sv
module park_occupancy_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       entry_sense = 1'b0;
    logic       exit_sense = 1'b0;
    logic [7:0] occ_bcd;
    logic       full_sign, gate_lower;

    int n_checks = 0;
    int n_fail = 0;
    int model = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    park_occupancy dut_i (
        .clk(clk), .rst_n(rst_n), .entry_sense(entry_sense), .exit_sense(exit_sense),
        .occ_bcd(occ_bcd), .full_sign(full_sign), .gate_lower(gate_lower)
    );

    function automatic logic [7:0] exp_bcd(int c);
        int r = c % 100;
        return {4'(r / 10), 4'(r % 10)};
    endfunction

    task automatic check_state(string req);
        logic exp_full = (model == 100);
        n_checks++;
        if (occ_bcd !== exp_bcd(model) || full_sign !== exp_full || gate_lower !== exp_full) begin
            n_fail++;
            $display("FAIL %s: bcd=%h full=%b gate=%b, expected bcd=%h full=%b gate=%b",
                     req, occ_bcd, full_sign, gate_lower, exp_bcd(model), exp_full, exp_full);
        end
    endtask

    // op: 0 entry, 1 exit, 2 both
    task automatic pulse(int op, int width, string req);
        @(negedge clk);
        entry_sense = (op != 1);
        exit_sense  = (op != 0);
        repeat (width) @(negedge clk);
        entry_sense = 1'b0;
        exit_sense  = 1'b0;
        repeat (4) @(negedge clk);
        if (op == 0 && model < 100) model++;
        if (op == 1 && model > 0) model--;
        check_state(req);
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        check_state("R1");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check_state("R1");

        // R5 latency: change on third rising edge
        @(negedge clk);
        entry_sense = 1'b1;
        repeat (2) @(negedge clk);
        check_state("R5 before third edge");
        @(negedge clk);
        model = 1;
        check_state("R5 third edge");
        entry_sense = 1'b0;
        repeat (4) @(negedge clk);
        check_state("R4 no extra step");

        pulse(0, 20, "R4 long pulse");
        pulse(1, 1, "R3");
        pulse(1, 1, "R3");
        pulse(1, 1, "R10 exit empty");
        pulse(2, 2, "R11 both at empty");
        for (int i = 0; i < 10; i++) pulse(0, 1, "R2 R6 carry");
        pulse(1, 3, "R6 borrow");
        pulse(2, 1, "R11 both");
        while (model < 100) pulse(0, 1 + int'($urandom_range(0, 2)), "R2 fill");
        check_state("R7 full");
        pulse(0, 2, "R8 entry full");
        pulse(2, 2, "R11 both full");
        pulse(1, 1, "R9 exit full");
        pulse(0, 1, "R7 refill");
        for (int i = 0; i < 300; i++) begin
            int r = int'($urandom_range(0, 9));
            int op = (r < 5) ? 0 : (r < 9) ? 1 : 2;
            pulse(op, 1 + int'($urandom_range(0, 4)), "R2 R3 R8 R9 R10 R11 random");
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule